// File: doc/BRIEF.md
# Self-Synchronizing NRZI Line Decoder with Word Packer

This block sits behind a clock-and-data recovery stage on a serial video link. Each cycle where the recovered clock delivers a sampled line bit, the block turns the level-per-bit NRZI signal back into plain NRZ by looking for transitions. It then strips the pseudorandom whitening that the transmitter applied with a nine-stage x^9 + x^4 + 1 generator. Because the descrambler taps the received scrambled bits directly instead of feeding its own output back, it needs no shared seed. It falls into step with any transmitter state once its register has filled.

Recovered bits come out one per valid input cycle, each with a qualifier. They are also packed into 10-bit words, earliest bit in the least significant position, with a strobe on every tenth valid bit counted from reset. The packer does no word alignment. Sync-word search, equalization and clock recovery belong to other blocks.

Top module: `nrzi_descrambler`

## Requirements
- R1: While `rstN` is low, and after a clock edge in reset, `dataBit`, `dataValid`, `wordOut` and `wordValid` are all zero.
- R2: The NRZ bit of a valid cycle is 1 when `lineBit` differs from the line bit of the previous valid cycle, and 0 when they are equal. The line level held before the first valid cycle after reset is 0.
- R3: The recovered bit equals n(t) XOR n(t-4) XOR n(t-9), where n(t-k) is the NRZ bit from k valid cycles earlier. NRZ history from before reset counts as 0.
- R4: A stream made by an x^9 + x^4 + 1 feedback scrambler followed by an NRZI encoder is recovered exactly from the eleventh valid bit onward. This holds for any nonzero scrambler start state and any starting line level.
- R5: A single inverted line bit at valid position p corrupts exactly the recovered bits at positions p, p+1, p+4, p+5, p+9 and p+10. All other bits are unaffected.
- R6: A cycle with `lineValid` low has no effect. `dataValid` and `wordValid` are low in the following cycle, `wordOut` and `dataBit` hold their values, and decoding resumes as if the idle cycle never occurred.
- R7: `wordValid` pulses together with every tenth `dataValid` counted from reset. `wordOut` bit k then holds the k-th of those ten recovered bits, so bit 0 is the earliest and bit 9 equals the `dataBit` of the same cycle.
- R8: `dataBit` and `dataValid` appear in the clock cycle after the line bit is sampled. `dataValid` follows `lineValid` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineBit | input | 1 | Sampled NRZI line level |
| lineValid | input | 1 | Qualifies `lineBit` in this cycle |
| dataBit | output | 1 | Recovered data bit |
| dataValid | output | 1 | Qualifies `dataBit` |
| wordOut | output | WORD_W | Packed word, earliest bit at bit 0 |
| wordValid | output | 1 | Pulses when `wordOut` is updated |

## Verification
The bench builds the block with its defaults: a 10-bit word, a nine-stage register and the low tap at stage 3. These values make both the word-wrap boundary and the deepest error offsets reachable. With a 10-bit word, the packer wraps many times within a few hundred bits, and the known word table lines up with the wrap right after one preamble word. The nine-deep register places the last corrupted bit of a single line error ten bits after the fault. A short injection window therefore shows the complete error footprint and the clean recovery that follows it.

// File: rtl/nrzi_desc_pkg.sv
package nrzi_desc_pkg;

  // Strobes issued by the control module to the datapath each cycle
  typedef struct packed {
    logic shiftEn;   // a line bit is accepted this cycle
    logic wordDone;  // this accepted bit completes a word
  } ctrlStrobe_t;

endpackage

// File: rtl/nrzi_desc_ctrl.sv
module nrzi_desc_ctrl
  import nrzi_desc_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineValid,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitPos;
  logic             atLast;

  assign atLast = (bitPos == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (lineValid) begin
      bitPos <= atLast ? '0 : bitPos + 1'b1;
    end
  end

  always_comb begin
    strobe.shiftEn  = lineValid;
    strobe.wordDone = lineValid && atLast;
  end

endmodule

// File: rtl/nrzi_desc_datapath.sv
module nrzi_desc_datapath
  import nrzi_desc_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LFSR_LEN = 9,
  parameter int TAP_LO   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineBit,
  input  ctrlStrobe_t       strobe,
  output logic              dataBit,
  output logic              dataValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  localparam int TAP_HI = LFSR_LEN - 1;

  logic                prevLine;
  logic [LFSR_LEN-1:0] nrzHist;
  logic [WORD_W-1:0]   packSh;
  logic                nrzBit;
  logic                plainBit;
  logic [WORD_W-1:0]   packNext;

  // Transition detector: a change of level marks a one
  assign nrzBit = lineBit ^ prevLine;

  // Feedforward descrambling on the history of received scrambled bits
  assign plainBit = nrzBit ^ nrzHist[TAP_HI] ^ nrzHist[TAP_LO];

  // Earliest bit drifts toward bit 0 as new bits enter at the top
  generate
    if (WORD_W > 1) begin : g_pack_wide
      assign packNext = {plainBit, packSh[WORD_W-1:1]};
    end else begin : g_pack_single
      assign packNext = plainBit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine  <= 1'b0;
      nrzHist   <= '0;
      packSh    <= '0;
      dataBit   <= 1'b0;
      wordOut   <= '0;
      dataValid <= 1'b0;
      wordValid <= 1'b0;
    end else begin
      dataValid <= strobe.shiftEn;
      wordValid <= strobe.wordDone;
      if (strobe.shiftEn) begin
        prevLine <= lineBit;
        nrzHist  <= {nrzHist[LFSR_LEN-2:0], nrzBit};
        packSh   <= packNext;
        dataBit  <= plainBit;
      end
      if (strobe.wordDone) begin
        wordOut <= packNext;
      end
    end
  end

endmodule

// File: rtl/nrzi_descrambler.sv
module nrzi_descrambler
  import nrzi_desc_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LFSR_LEN = 9,
  parameter int TAP_LO   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineBit,
  input  logic              lineValid,
  output logic              dataBit,
  output logic              dataValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  ctrlStrobe_t strobe;

  nrzi_desc_ctrl #(
    .WORD_W(WORD_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineValid(lineValid),
    .strobe   (strobe)
  );

  nrzi_desc_datapath #(
    .WORD_W  (WORD_W),
    .LFSR_LEN(LFSR_LEN),
    .TAP_LO  (TAP_LO)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineBit  (lineBit),
    .strobe   (strobe),
    .dataBit  (dataBit),
    .dataValid(dataValid),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

endmodule

// File: rtl/nrzi_descrambler_checker.sv
module nrzi_descrambler_checker #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineValid,
  input logic              dataBit,
  input logic              dataValid,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid
);

  localparam int SEEN_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic              primed;
  logic [SEEN_W-1:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      seen   <= '0;
    end else begin
      primed <= 1'b1;
      if (dataValid) begin
        seen <= (seen == SEEN_W'(WORD_W - 1)) ? '0 : seen + 1'b1;
      end
    end
  end

  // R8: qualifier trails the input qualifier by one cycle
  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (dataValid == $past(lineValid)));

  // R6: an idle input cycle leaves the outputs untouched
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(lineValid)) |-> ($stable(wordOut) && $stable(dataBit) && !wordValid));

  // R7: a word strobe always accompanies a data strobe
  p_word_with_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> dataValid);

  // R7: the newest bit of a word is the bit presented alongside it
  p_word_top_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordOut[WORD_W-1] == dataBit));

  // R7: word strobes land on every WORD_W-th data strobe since reset
  p_word_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (wordValid == (seen == SEEN_W'(WORD_W - 1))));

endmodule

bind nrzi_descrambler nrzi_descrambler_checker #(
  .WORD_W(WORD_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .lineValid(lineValid),
  .dataBit  (dataBit),
  .dataValid(dataValid),
  .wordOut  (wordOut),
  .wordValid(wordValid)
);

// File: tb/nrzi_descrambler_tb.sv
module nrzi_descrambler_tb_top;

  localparam int WORD_W = 10;
  localparam int NVEC   = 8;
  localparam logic [WORD_W-1:0] VEC [NVEC] = '{
    10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h001, 10'h200, 10'h0F0, 10'h3C7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineBit = 1'b0;
  logic lineValid = 1'b0;
  logic dataBit;
  logic dataValid;
  logic [WORD_W-1:0] wordOut;
  logic wordValid;

  int checks = 0;
  int errors = 0;
  int validSinceReset = 0;
  logic [WORD_W-1:0] wordAcc = '0;

  // transmitter reference model
  logic [8:0] txQ;
  logic txLine;

  always #10 clk = ~clk;

  nrzi_descrambler dut_i (
    .clk(clk), .rstN(rstN), .lineBit(lineBit), .lineValid(lineValid),
    .dataBit(dataBit), .dataValid(dataValid), .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(dataBit == 1'b0 && dataValid == 1'b0 && wordValid == 1'b0, "R1 flags", {dataBit, dataValid, wordValid}, 0);
    chk(wordOut == '0, "R1 word", wordOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    validSinceReset = 0;
    wordAcc = '0;
  endtask

  task automatic driveLine(input logic l, output logic got);
    @(negedge clk);
    lineBit = l;
    lineValid = 1'b1;
    @(posedge clk);
    #1;
    chk(dataValid === 1'b1, "R8 latency", dataValid, 1);
    got = dataBit;
    wordAcc = {got, wordAcc[WORD_W-1:1]};
    if (validSinceReset % WORD_W == WORD_W - 1) begin
      chk(wordValid === 1'b1, "R7 strobe", wordValid, 1);
      chk(wordOut === wordAcc, "R7 packing", wordOut, wordAcc);
    end else begin
      chk(wordValid === 1'b0, "R7 no strobe", wordValid, 0);
    end
    validSinceReset++;
  endtask

  task automatic idleCycle();
    logic [WORD_W-1:0] heldWord;
    logic heldBit;
    heldWord = wordOut;
    heldBit = dataBit;
    @(negedge clk);
    lineValid = 1'b0;
    lineBit = 1'($urandom);
    @(posedge clk);
    #1;
    chk(dataValid == 1'b0 && wordValid == 1'b0, "R6 idle flags", {dataValid, wordValid}, 0);
    chk(wordOut == heldWord && dataBit == heldBit, "R6 idle hold", wordOut, heldWord);
  endtask

  // scramble one data bit, NRZI-encode it and send; flip inverts the wire only
  task automatic sendData(input logic d, input logic flip, output logic got);
    logic s;
    s = d ^ txQ[8] ^ txQ[3];
    txQ = {txQ[7:0], s};
    txLine = txLine ^ s;
    driveLine(txLine ^ flip, got);
  endtask

  initial begin
    int t;
    logic got;
    logic [15:0] errMask;
    logic [9:0] dataLog [0:31];

    // R1: reset state
    doReset();

    // R2, R3: constant line gives no transitions, hence all zeros
    for (int i = 0; i < 12; i++) begin
      driveLine(1'b0, got);
      chk(got == 1'b0, "R2 steady line", got, 0);
    end
    // R2, R3: toggling line makes every NRZ bit one
    t = 0;
    for (int i = 0; i < 14; i++) begin
      driveLine(1'(i % 2 == 0), got);
      chk(got == ((t < 4) ? 1'b0 : 1'b0) ^ ((t < 4 || t >= 9) ? 1'b1 : 1'b0), "R3 toggle pattern", got, (t < 4 || t >= 9));
      t++;
    end

    // R4, R7: word table after one preamble word from a random transmitter state
    doReset();
    txQ = 9'($urandom_range(1, 511));
    txLine = 1'($urandom);
    for (int i = 0; i < WORD_W; i++) sendData(1'($urandom), 1'b0, got);
    for (int v = 0; v < NVEC; v++) begin
      for (int b = 0; b < WORD_W; b++) begin
        sendData(VEC[v][b], 1'b0, got);
        chk(got == VEC[v][b], "R4 table bit", got, VEC[v][b]);
      end
      chk(wordValid && wordOut == VEC[v], "R7 table word", wordOut, VEC[v]);
    end

    // R4, R6: random data with idle gaps, several seeds
    for (int seed = 0; seed < 4; seed++) begin
      doReset();
      txQ = 9'($urandom_range(1, 511));
      txLine = 1'($urandom);
      for (int i = 0; i < 150; i++) begin
        logic d;
        d = 1'($urandom);
        if ($urandom_range(0, 5) == 0) idleCycle();
        sendData(d, 1'b0, got);
        if (i >= 10) chk(got == d, "R4 random recovery", got, d);
      end
    end

    // R5: single line bit inversion footprint
    for (int k = 0; k < 32; k++) dataLog[k] = '0;
    errMask = '0;
    for (int i = 0; i < 16; i++) begin
      logic d;
      d = 1'($urandom);
      sendData(d, (i == 0), got);
      errMask[i] = (got != d);
    end
    chk(errMask == 16'h0633, "R5 error footprint", errMask, 16'h0633);
    for (int i = 0; i < 20; i++) begin
      logic d;
      d = 1'($urandom);
      sendData(d, 1'b0, got);
      chk(got == d, "R5 clean after error", got, d);
    end

    // R1: reset in mid-stream restarts word counting
    doReset();
    for (int i = 0; i < 2 * WORD_W; i++) driveLine(1'($urandom), got);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule